// File: doc/BRIEF.md
# PLL Setting Search Engine

This block searches for the phase-locked loop setting whose output rate comes closest to a requested rate without going above it. It is given a parent (reference) rate and a target rate. It walks every combination of a feedback multiplier code, a one-bit pre-divider code and a two-bit power-of-two post-divider code. For each combination it computes the resulting rate and keeps the best one. At the end it reports the chosen codes, the packed configuration word, the achieved rate and a status flag.

A candidate's rate is parent × (mul+1) × 2 / ((d1+1) × 2^d2), with the division truncated. Here mul runs from 0 to 127, d1 from 0 to 1 and d2 from 0 to 3. The search visits the codes in a fixed nested order: d1 from 1 down to 0 (outermost), then d2 from 3 down to 0, then mul from 0 up to 127 (innermost). It stops as soon as a candidate matches the target exactly. Each candidate is examined in one clock cycle.

Requests enter through a valid/ready handshake. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole search, so a request offered during a search is not taken, and the requester must hold it until `req_ready` returns. The result side has no back-pressure. `done` pulses for one cycle, and the result outputs hold their values until the next request is accepted.

Top module: `pll_cfg_search`

## Requirements
- R1: After reset, `req_ready` is 1, and `done`, `err`, `cfg_mul`, `cfg_d1`, `cfg_d2`, `cfg_word` and `rate` are all 0.
- R2: On completion without error, `rate` equals parent × (cfg_mul+1) × 2 / ((cfg_d1+1) × 2^cfg_d2), truncated, and never exceeds the target. Among all candidates at or below the target, it has the smallest target-minus-rate error.
- R3: Candidates are visited with d1 descending 1..0 (outer), d2 descending 3..0, and mul ascending 0..127 (inner). When several candidates share the smallest error, the one reached first in this order is reported.
- R4: The search ends at the first candidate whose rate equals the target exactly. `done` goes high one cycle after the cycle in which that candidate is examined. A target met exactly by the first candidate (d1=1, d2=3, mul=0) gives `done` on the second rising edge, counting the accepting edge as the first.
- R5: If no candidate is at or below the target, `err` is 1 at `done`, and `cfg_mul`, `cfg_d1`, `cfg_d2`, `cfg_word` and `rate` are 0. On any successful search `err` is 0.
- R6: `cfg_word` is 32 bits: mul in bits 22:16, d1 in bit 8, d2 in bits 1:0, and all other bits 0.
- R7: `req_ready` is 1 only while no search is running. A `req_valid` raised during a search is ignored, and the reported result belongs to the accepted request.
- R8: `done` is high for exactly one cycle per search, and the result outputs keep their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| parent_freq | input | 16 | Parent rate, sampled at acceptance |
| target_freq | input | 16 | Requested rate, sampled at acceptance |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | No candidate at or below the target |
| cfg_mul | output | 7 | Chosen multiplier code |
| cfg_d1 | output | 1 | Chosen pre-divider code |
| cfg_d2 | output | 2 | Chosen post-divider exponent |
| cfg_word | output | 32 | Packed configuration word |
| rate | output | 16 | Achieved rate of the chosen setting |

## Verification
The bench computes the best setting with integer arithmetic over the whole code space and compares it with the block for many parent/target pairs. These include a dense sweep of small targets where ties in error are common. A design that replaced the best candidate on equal error, or visited the codes in another order, would report a later setting with the same rate. A design that did not stop on an exact hit would show longer latency and could report a different setting.

Targets below every candidate must raise `err` with zeroed fields. A design that kept stale fields, or compared with `<` instead of `<=`, would fail there or on the exact-hit cases. A request offered mid-search must leave the running result untouched.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  localparam int CFG_W   = 32;
  localparam int MUL_LSB = 16;
  localparam int D1_POS  = 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } search_st_e;

  function automatic logic [CFG_W-1:0] pack_cfg(input logic [7:0] m,
                                                input logic       d1,
                                                input logic [1:0] d2);
    logic [CFG_W-1:0] w;
    w = '0;
    w[MUL_LSB +: 8] = m;
    w[D1_POS]       = d1;
    w[1:0]          = d2;
    return w;
  endfunction

endpackage

// File: rtl/pll_scan_gen.sv
module pll_scan_gen #(
  parameter int FREQ_W = 16,
  parameter int MUL_W  = 7,
  parameter int D2_W   = 2,
  parameter int ACC_W  = FREQ_W + MUL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              skip_row,
  input  logic [FREQ_W-1:0] parent_in,
  output logic [MUL_W-1:0]  mul,
  output logic              d1,
  output logic [D2_W-1:0]   d2,
  output logic [ACC_W-1:0]  cand,
  output logic              last_step
);

  localparam logic [MUL_W-1:0] MUL_MAX = '1;
  localparam logic [D2_W-1:0]  D2_MAX  = '1;

  logic [FREQ_W-1:0] parent_q;
  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  pstep;
  logic [ACC_W-1:0]  pstep_in;
  logic [D2_W:0]     shamt;
  logic              row_end;

  // acc_q holds parent*2*(mul+1); the divider is a power of two
  assign pstep    = ACC_W'({parent_q, 1'b0});
  assign pstep_in = ACC_W'({parent_in, 1'b0});
  assign shamt    = {1'b0, d2} + {{D2_W{1'b0}}, d1};
  assign cand     = acc_q >> shamt;
  assign row_end  = (mul == MUL_MAX) || skip_row;
  assign last_step = row_end && !d1 && (d2 == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parent_q <= '0;
      acc_q    <= '0;
      mul      <= '0;
      d1       <= 1'b0;
      d2       <= '0;
    end else if (load) begin
      parent_q <= parent_in;
      acc_q    <= pstep_in;
      mul      <= '0;
      d1       <= 1'b1;
      d2       <= D2_MAX;
    end else if (step) begin
      if (row_end) begin
        mul   <= '0;
        acc_q <= pstep;
        if (d2 == '0) begin
          d2 <= D2_MAX;
          d1 <= 1'b0;
        end else begin
          d2 <= d2 - 1'b1;
        end
      end else begin
        mul   <= mul + 1'b1;
        acc_q <= acc_q + pstep;
      end
    end
  end

  // R3: inside a row the multiplier code climbs by one per step
  assert_mul_ascends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !row_end) |=> (mul == $past(mul) + 1'b1));

  // R3: leaving a row restarts the multiplier and lowers the divider codes
  assert_row_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && row_end && (d2 != '0)) |=> ((mul == '0) && (d2 == $past(d2) - 1'b1)));

endmodule

// File: rtl/pll_best_keep.sv
module pll_best_keep #(
  parameter int FREQ_W = 16,
  parameter int MUL_W  = 7,
  parameter int D2_W   = 2,
  parameter int ACC_W  = FREQ_W + MUL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              eval,
  input  logic [FREQ_W-1:0] target,
  input  logic [ACC_W-1:0]  cand,
  input  logic [MUL_W-1:0]  mul,
  input  logic              d1,
  input  logic [D2_W-1:0]   d2,
  output logic              fits,
  output logic              exact,
  output logic              have,
  output logic [MUL_W-1:0]  best_mul,
  output logic              best_d1,
  output logic [D2_W-1:0]   best_d2,
  output logic [FREQ_W-1:0] best_rate
);

  logic [FREQ_W-1:0] best_err_q;
  logic [FREQ_W-1:0] err_now;
  logic              upd;

  assign fits    = cand <= ACC_W'(target);
  assign err_now = target - cand[FREQ_W-1:0];
  assign exact   = eval && fits && (err_now == '0);
  assign upd     = eval && fits && (!have || (err_now < best_err_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have       <= 1'b0;
      best_mul   <= '0;
      best_d1    <= 1'b0;
      best_d2    <= '0;
      best_rate  <= '0;
      best_err_q <= '1;
    end else if (clear) begin
      have       <= 1'b0;
      best_mul   <= '0;
      best_d1    <= 1'b0;
      best_d2    <= '0;
      best_rate  <= '0;
      best_err_q <= '1;
    end else if (upd) begin
      have       <= 1'b1;
      best_mul   <= mul;
      best_d1    <= d1;
      best_d2    <= d2;
      best_rate  <= cand[FREQ_W-1:0];
      best_err_q <= err_now;
    end
  end

  // R2: a stored best never lies above the target
  assert_best_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (have && !clear) |-> (best_rate <= target));

  // R3: a replacement must strictly shrink the error
  assert_best_improves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && have && !clear) |=> (best_err_q < $past(best_err_q)));

endmodule

// File: rtl/pll_cfg_search.sv
module pll_cfg_search
  import pll_search_pkg::*;
#(
  parameter int FREQ_W = 16,
  parameter int MUL_W  = 7,
  parameter int D2_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FREQ_W-1:0] parent_freq,
  input  logic [FREQ_W-1:0] target_freq,
  output logic              done,
  output logic              err,
  output logic [MUL_W-1:0]  cfg_mul,
  output logic              cfg_d1,
  output logic [D2_W-1:0]   cfg_d2,
  output logic [CFG_W-1:0]  cfg_word,
  output logic [FREQ_W-1:0] rate
);

  localparam int ACC_W = FREQ_W + MUL_W + 1;

  search_st_e        state_q;
  logic [FREQ_W-1:0] target_q;
  logic              accept;
  logic              scanning;
  logic              finish;
  logic              fits;
  logic              exact;
  logic              have;
  logic              last_step;
  logic [MUL_W-1:0]  c_mul;
  logic              c_d1;
  logic [D2_W-1:0]   c_d2;
  logic [ACC_W-1:0]  cand;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign scanning  = (state_q == ST_SCAN);
  assign finish    = scanning && (exact || last_step);

  pll_scan_gen #(
    .FREQ_W(FREQ_W), .MUL_W(MUL_W), .D2_W(D2_W), .ACC_W(ACC_W)
  ) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .step      (scanning),
    .skip_row  (scanning && !fits),
    .parent_in (parent_freq),
    .mul       (c_mul),
    .d1        (c_d1),
    .d2        (c_d2),
    .cand      (cand),
    .last_step (last_step)
  );

  pll_best_keep #(
    .FREQ_W(FREQ_W), .MUL_W(MUL_W), .D2_W(D2_W), .ACC_W(ACC_W)
  ) u_keep (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .eval      (scanning),
    .target    (target_q),
    .cand      (cand),
    .mul       (c_mul),
    .d1        (c_d1),
    .d2        (c_d2),
    .fits      (fits),
    .exact     (exact),
    .have      (have),
    .best_mul  (cfg_mul),
    .best_d1   (cfg_d1),
    .best_d2   (cfg_d2),
    .best_rate (rate)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      target_q <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        state_q  <= ST_SCAN;
        target_q <= target_freq;
        err      <= 1'b0;
      end else if (finish) begin
        state_q <= ST_IDLE;
        err     <= !(have || fits);
      end
    end
  end

  assign cfg_word = pack_cfg(8'(cfg_mul), cfg_d1, 2'(cfg_d2));

  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: an accepted request closes the input until the search ends
  assert_ready_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R5: a failed search reports an all-zero word and rate
  assert_err_zero_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> ((cfg_word == '0) && (rate == '0)));

  // R8: results do not move while idle with no new request
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !accept && !done) |=> $stable(cfg_word));

endmodule

// File: tb/pll_cfg_search_tb.sv
`timescale 1ns/1ps
module pll_cfg_search_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] parent_freq = '0;
  logic [15:0] target_freq = '0;
  logic        done, err;
  logic [6:0]  cfg_mul;
  logic        cfg_d1;
  logic [1:0]  cfg_d2;
  logic [31:0] cfg_word;
  logic [15:0] rate;

  int checks = 0;
  int fails  = 0;
  int last_cycles = 0;

  always #2 clk = ~clk;

  pll_cfg_search u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .parent_freq(parent_freq), .target_freq(target_freq), .done(done), .err(err),
    .cfg_mul(cfg_mul), .cfg_d1(cfg_d1), .cfg_d2(cfg_d2), .cfg_word(cfg_word), .rate(rate)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model(input longint p, input longint t,
                       output longint em, output longint ed1, output longint ed2,
                       output longint er, output bit eerr);
    longint best;
    bit found;
    found = 0; best = 0; em = 0; ed1 = 0; ed2 = 0; er = 0;
    for (int a = 1; a >= 0; a--)
      for (int b = 3; b >= 0; b--)
        for (int m = 0; m <= 127; m++) begin
          longint c, e;
          c = (p * (m + 1) * 2) / ((a + 1) * (longint'(1) << b));
          if (c > t) continue;
          e = t - c;
          if (e == 0) begin
            em = m; ed1 = a; ed2 = b; er = c; eerr = 0;
            return;
          end
          if (!found || e < best) begin
            found = 1; best = e; em = m; ed1 = a; ed2 = b; er = c;
          end
        end
    eerr = !found;
  endtask

  task automatic launch(input int p, input int t);
    while (!req_ready) @(negedge clk);
    parent_freq = 16'(p);
    target_freq = 16'(t);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    last_cycles = 1;
  endtask

  task automatic wait_done;
    int guard = 0;
    while (!done && guard < 3000) begin
      @(negedge clk);
      last_cycles++;
      guard++;
    end
  endtask

  task automatic verify(input int p, input int t);
    longint em, ed1, ed2, er, ew;
    bit eerr;
    model(p, t, em, ed1, ed2, er, eerr);
    ew = (em << 16) | (ed1 << 8) | ed2;
    check(done == 1'b1, "R8", "done seen", done, 1);
    check(err == eerr, "R5", "err flag", err, eerr);
    check({cfg_mul, cfg_d1, cfg_d2} == {7'(em), 1'(ed1), 2'(ed2)}, "R3",
          "fields {mul,d1,d2}", {cfg_mul, cfg_d1, cfg_d2}, {7'(em), 1'(ed1), 2'(ed2)});
    check(rate == 16'(er), "R2", "achieved rate", rate, er);
    check(cfg_word == 32'(ew), "R6", "packed word", cfg_word, ew);
    @(negedge clk);
    check(done == 1'b0, "R8", "done one cycle", done, 0);
    check(cfg_word == 32'(ew), "R8", "word held", cfg_word, ew);
  endtask

  task automatic run(input int p, input int t);
    launch(p, t);
    wait_done();
    verify(p, t);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int plist[7] = '{1, 3, 7, 25, 100, 1000, 65535};
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    check({done, err} == 2'b00, "R1", "done/err after reset", {done, err}, 0);
    check(cfg_word == 32'd0 && rate == 16'd0, "R1", "result after reset", cfg_word, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 exact hit on the very first candidate: 8*2/16 = 1
    launch(8, 1);
    check(req_ready == 1'b0, "R7", "ready low while busy", req_ready, 0);
    wait_done();
    check(last_cycles == 2, "R4", "exact first-candidate latency", last_cycles, 2);
    verify(8, 1);

    // R4 exact hit deeper in the scan: 25*2*16/16 = 50
    run(25, 50);

    // R5 no candidate fits
    run(25, 0);
    run(65535, 1);

    // R7 request offered mid-search is ignored
    launch(1000, 50000);
    repeat (5) @(negedge clk);
    parent_freq = 16'd3;
    target_freq = 16'd7;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    verify(1000, 50000);
    check(req_ready == 1'b1, "R7", "ready after search", req_ready, 1);

    // R2/R3 dense sweep with many ties
    for (int t = 0; t <= 40; t++) run(5, t);

    // R2/R3 assorted parents and targets
    foreach (plist[i]) begin
      int p;
      int tl[6];
      p = plist[i];
      tl[0] = 1;
      tl[1] = p;
      tl[2] = (3 * p + 1 > 65535) ? 65535 : 3 * p + 1;
      tl[3] = (17 * p / 3 > 65535) ? 40001 : 17 * p / 3;
      tl[4] = (100 * p > 65535) ? 65535 : 100 * p;
      tl[5] = 65535;
      foreach (tl[k]) run(p, tl[k]);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule